// File: doc/BRIEF.md
# Serial Command Decoder with Double-Buffered Code Registers

This block sits between a three-wire serial host port (active-low select, serial clock, serial data) and the code input of a converter. The host sends 16-bit frames, most significant bit first. The two leading bits choose an operation, and the remaining 14 bits carry either a new code or, for the all-ones operation, a three-bit sub-opcode at the top of the payload. Two registers hold codes. One is a staging register. The other is the live output code. The host can load the staging register alone, load both registers in one frame, or copy the staging register into the live register.

The block has three further outputs. A spare logic output is set and cleared by command. A shutdown flag is entered by command and left by either frame that loads the live register. A serial data output returns every bit, delayed by one frame length, so that several devices can be chained. That output launches bits on the rising serial clock by default, or half a serial clock later on the falling edge. An active-low clear input forces both code registers to zero or to midscale, as a reset-select input chooses, and returns the spare output to low. All serial inputs are sampled by the system clock through a short synchronizer, so the serial clock must run well below the system clock.

Top module: `dbuf_serial_ctl`

## Requirements
- R1: After synchronous reset, code_out is 0x0000, aux_out is 0, shut_out is 0, sdo is 0, and the serial output is in rising-edge mode.
- R2: A frame is taken as the last 16 bits shifted in while cs_n is low. Bits [15:14] are the operation and bits [13:0] the payload. It executes when cs_n rises. If fewer than 16 rising serial clocks arrived since cs_n fell, the frame is dropped. If more arrived, the last 16 are used.
- R3: While cs_n is high, serial clock edges and sdi shift nothing and execute nothing.
- R4: Operation 00 writes the payload into the staging register and leaves code_out unchanged.
- R5: Operation 01 writes the payload into both the staging register and code_out, and clears shut_out.
- R6: Operation 10 copies the staging register into code_out, ignores its payload, and clears shut_out.
- R7: Operation 11 decodes payload[13:11]. 00x is a no-op. 01x sets shut_out. 100 drives aux_out low and 101 drives it high. 110 selects falling-edge output mode and 111 selects rising-edge mode. Codes that do not name aux_out leave it unchanged.
- R8: In rising-edge mode, sdo changes after a rising serial clock and carries the bit received 16 rising edges earlier. In falling-edge mode, the same bit appears only after the following falling serial clock.
- R9: While clr_n is low, code_out and the staging register take 0x2000 if mid_sel is high and 0x0000 if it is low, and aux_out goes low.
- R10: While shut_out is high, sdo holds its value and aux_out keeps its state. Frames are still decoded.
- R11: A frame sent as two 8-bit bursts, with cs_n held low between them, acts the same as one 16-bit burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low frame select |
| sck | input | 1 | Serial clock, sampled by clk |
| sdi | input | 1 | Serial data in, MSB first |
| clr_n | input | 1 | Active-low clear of the code registers and aux_out |
| mid_sel | input | 1 | Clear target: 1 gives midscale, 0 gives zero |
| code_out | output | 14 | Live output code |
| shut_out | output | 1 | Shutdown flag |
| aux_out | output | 1 | Spare logic output |
| sdo | output | 1 | Serial data out for chaining |

## Verification
The bench builds the block with its defaults: a 14-bit payload and a two-stage input synchronizer. With a 14-bit payload the midscale code is 0x2000 and the sub-opcode occupies bits [13:11], so every operation and sub-opcode can be reached with exact, known frame words. The serial clock runs at eight system cycles per bit, so each rising and falling serial edge settles on its own. This lets the bench tell the two output timing modes apart bit by bit, and separate dropped, overlong and split frames by where cs_n rises.

// File: rtl/dbuf_serial_pkg.sv
package dbuf_serial_pkg;

  typedef enum logic [1:0] {
    OP_STAGE  = 2'b00,
    OP_BOTH   = 2'b01,
    OP_COPY   = 2'b10,
    OP_SPCL   = 2'b11
  } op_e;

  typedef enum logic [2:0] {
    SUB_IDLE,
    SUB_SLEEP,
    SUB_AUX_LO,
    SUB_AUX_HI,
    SUB_LATE,
    SUB_EARLY
  } sub_e;

  function automatic sub_e decode_sub(input logic [2:0] s);
    sub_e r;
    casez (s)
      3'b00?:  r = SUB_IDLE;
      3'b01?:  r = SUB_SLEEP;
      3'b100:  r = SUB_AUX_LO;
      3'b101:  r = SUB_AUX_HI;
      3'b110:  r = SUB_LATE;
      default: r = SUB_EARLY;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/dbuf_serial_sync.sv
module dbuf_serial_sync #(
  parameter int               WIDTH  = 5,
  parameter int               STAGES = 2,
  parameter logic [WIDTH-1:0] INIT   = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] chain [STAGES];

  for (genvar gi = 0; gi < STAGES; gi++) begin : g_stage
    if (gi == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[gi] <= INIT;
        else     chain[gi] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[gi] <= INIT;
        else     chain[gi] <= chain[gi-1];
      end
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/dbuf_serial_frame.sv
module dbuf_serial_frame #(
  parameter int FRAME_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sck_s,
  input  logic               cs_n_s,
  input  logic               sdi_s,
  input  logic               late_mode,
  input  logic               hold_sdo,
  output logic [FRAME_W-1:0] word,
  output logic               frame_exec,
  output logic               sdo
);

  localparam int                 CNT_W = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0]   FULL  = CNT_W'(FRAME_W);

  logic               sck_d, cs_d;
  logic [CNT_W-1:0]   cnt;
  logic [FRAME_W-1:0] shreg;
  logic               spill;
  logic               sdo_q;
  logic               exec_q;
  logic               sck_rise, sck_fall, cs_rise;

  assign sck_rise = sck_s & ~sck_d & ~cs_n_s;
  assign sck_fall = ~sck_s & sck_d & ~cs_n_s;
  assign cs_rise  = cs_n_s & ~cs_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_d  <= 1'b0;
      cs_d   <= 1'b1;
      cnt    <= '0;
      shreg  <= '0;
      spill  <= 1'b0;
      sdo_q  <= 1'b0;
      exec_q <= 1'b0;
    end else begin
      sck_d  <= sck_s;
      cs_d   <= cs_n_s;
      exec_q <= cs_rise && (cnt == FULL);
      if (cs_n_s)
        cnt <= '0;
      else if (sck_rise && cnt != FULL)
        cnt <= cnt + 1'b1;
      if (sck_rise) begin
        shreg <= {shreg[FRAME_W-2:0], sdi_s};
        spill <= shreg[FRAME_W-1];
      end
      if (!hold_sdo) begin
        if (!late_mode && sck_rise)
          sdo_q <= shreg[FRAME_W-1];
        else if (late_mode && sck_fall)
          sdo_q <= spill;
      end
    end
  end

  assign word       = shreg;
  assign frame_exec = exec_q;
  assign sdo        = sdo_q;

endmodule

// File: rtl/dbuf_serial_regs.sv
module dbuf_serial_regs
  import dbuf_serial_pkg::*;
#(
  parameter int DATA_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              exec,
  input  logic [DATA_W+1:0] word,
  input  logic              clr_n_s,
  input  logic              mid_sel_s,
  output logic [DATA_W-1:0] code,
  output logic              aux,
  output logic              shut,
  output logic              late_mode
);

  localparam logic [DATA_W-1:0] MID_CODE = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0] stage_q, code_q, preset, payload;
  logic              aux_q, shut_q, late_q;
  op_e               op;
  sub_e              sub;

  assign payload = word[DATA_W-1:0];
  assign op      = op_e'(word[DATA_W+1:DATA_W]);
  assign sub     = decode_sub(payload[DATA_W-1 -: 3]);
  assign preset  = mid_sel_s ? MID_CODE : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= '0;
      code_q  <= '0;
      aux_q   <= 1'b0;
      shut_q  <= 1'b0;
      late_q  <= 1'b0;
    end else begin
      if (exec) begin
        unique case (op)
          OP_STAGE: stage_q <= payload;
          OP_BOTH: begin
            stage_q <= payload;
            code_q  <= payload;
            shut_q  <= 1'b0;
          end
          OP_COPY: begin
            code_q <= stage_q;
            shut_q <= 1'b0;
          end
          OP_SPCL: begin
            unique case (sub)
              SUB_SLEEP:  shut_q <= 1'b1;
              SUB_AUX_LO: aux_q  <= 1'b0;
              SUB_AUX_HI: aux_q  <= 1'b1;
              SUB_LATE:   late_q <= 1'b1;
              SUB_EARLY:  late_q <= 1'b0;
              default:    ;
            endcase
          end
          default: ;
        endcase
      end
      if (!clr_n_s) begin
        stage_q <= preset;
        code_q  <= preset;
        aux_q   <= 1'b0;
      end
    end
  end

  assign code      = code_q;
  assign aux       = aux_q;
  assign shut      = shut_q;
  assign late_mode = late_q;

endmodule

// File: rtl/dbuf_serial_ctl.sv
module dbuf_serial_ctl #(
  parameter int DATA_W      = 14,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              sdi,
  input  logic              clr_n,
  input  logic              mid_sel,
  output logic [DATA_W-1:0] code_out,
  output logic              shut_out,
  output logic              aux_out,
  output logic              sdo
);

  localparam int FRAME_W = DATA_W + 2;

  logic [4:0]         raw_in, sync_out;
  logic               cs_n_s, sck_s, sdi_s, clr_n_s, mid_sel_s;
  logic [FRAME_W-1:0] frame_word;
  logic               frame_exec;
  logic               late_mode;

  assign raw_in = {cs_n, sck, sdi, clr_n, mid_sel};

  dbuf_serial_sync #(
    .WIDTH (5),
    .STAGES(SYNC_STAGES),
    .INIT  (5'b10010)
  ) u_sync (
    .clk(clk),
    .rst(rst),
    .d  (raw_in),
    .q  (sync_out)
  );

  assign {cs_n_s, sck_s, sdi_s, clr_n_s, mid_sel_s} = sync_out;

  dbuf_serial_frame #(
    .FRAME_W(FRAME_W)
  ) u_frame (
    .clk       (clk),
    .rst       (rst),
    .sck_s     (sck_s),
    .cs_n_s    (cs_n_s),
    .sdi_s     (sdi_s),
    .late_mode (late_mode),
    .hold_sdo  (shut_out),
    .word      (frame_word),
    .frame_exec(frame_exec),
    .sdo       (sdo)
  );

  dbuf_serial_regs #(
    .DATA_W(DATA_W)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .exec     (frame_exec),
    .word     (frame_word),
    .clr_n_s  (clr_n_s),
    .mid_sel_s(mid_sel_s),
    .code     (code_out),
    .aux      (aux_out),
    .shut     (shut_out),
    .late_mode(late_mode)
  );

endmodule

// File: rtl/dbuf_serial_ctl_chk.sv
module dbuf_serial_ctl_chk #(
  parameter int DATA_W = 14
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] code,
  input logic              aux,
  input logic              shut,
  input logic              sdo,
  input logic              exec,
  input logic              clr_q,
  input logic              cs_q,
  input logic [DATA_W+1:0] word
);

  localparam logic [DATA_W-1:0] MID_CODE = {1'b1, {(DATA_W-1){1'b0}}};

  logic rst_prev;
  always_ff @(posedge clk) rst_prev <= rst;

  // R1
  always_ff @(posedge clk) begin
    if (rst_prev) begin
      reset_state_chk: assert (code == '0 && !aux && !shut && !sdo)
        else $error("reset state wrong");
    end
  end

  // R9
  clear_preset_chk: assert property (@(posedge clk) disable iff (rst)
    !clr_q |=> (!aux && (code == '0 || code == MID_CODE)));

  // R10
  sleep_hold_chk: assert property (@(posedge clk) disable iff (rst)
    shut |=> $stable(sdo));

  // R7
  aux_by_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    (!exec && clr_q) |=> $stable(aux));

  // R4
  code_by_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    (!exec && clr_q) |=> $stable(code));

  // R3
  idle_shift_chk: assert property (@(posedge clk) disable iff (rst)
    cs_q |=> $stable(word));

endmodule

bind dbuf_serial_ctl dbuf_serial_ctl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk  (clk),
  .rst  (rst),
  .code (code_out),
  .aux  (aux_out),
  .shut (shut_out),
  .sdo  (sdo),
  .exec (frame_exec),
  .clr_q(clr_n_s),
  .cs_q (cs_n_s),
  .word (frame_word)
);

// File: tb/dbuf_serial_ctl_bench.sv
module dbuf_serial_ctl_bench;

  localparam int HALF = 4;

  logic        clk = 1'b0;
  logic        rst, cs_n, sck, sdi, clr_n, mid_sel;
  logic [13:0] code_out;
  logic        shut_out, aux_out, sdo;

  int n_vec = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  dbuf_serial_ctl u_dbuf_serial_ctl (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .sdi(sdi),
    .clr_n(clr_n), .mid_sel(mid_sel), .code_out(code_out),
    .shut_out(shut_out), .aux_out(aux_out), .sdo(sdo)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // chk: 0 none, 1 compare sdo with ref frame, 2 compare sdo with constant cbit
  task automatic shift_bits(input int n, input logic [31:0] data, input int chk,
                            input logic [15:0] ref_w, input logic late, input logic cbit);
    for (int j = 1; j <= n; j++) begin
      sck = 1'b0;
      sdi = data[n-j];
      wait_clk(HALF);
      if (chk == 1 && j >= 2) check("R8 sdo low phase", {15'd0, sdo}, {15'd0, ref_w[17-j]});
      if (chk == 2) check("R10 sdo held", {15'd0, sdo}, {15'd0, cbit});
      sck = 1'b1;
      wait_clk(HALF);
      if (chk == 1) begin
        if (!late)       check("R8 sdo rising mode", {15'd0, sdo}, {15'd0, ref_w[16-j]});
        else if (j >= 2) check("R8 sdo falling mode", {15'd0, sdo}, {15'd0, ref_w[17-j]});
      end
      if (chk == 2) check("R10 sdo held", {15'd0, sdo}, {15'd0, cbit});
    end
    sck = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic frame(input logic [15:0] w);
    cs_n = 1'b0;
    wait_clk(HALF);
    shift_bits(16, {16'd0, w}, 0, 16'd0, 1'b0, 1'b0);
    cs_n = 1'b1;
    wait_clk(2 * HALF);
  endtask

  task automatic t_reset;
    check("R1 code", {2'b0, code_out}, 16'h0000);
    check("R1 aux", {15'd0, aux_out}, 16'd0);
    check("R1 shut", {15'd0, shut_out}, 16'd0);
    check("R1 sdo", {15'd0, sdo}, 16'd0);
  endtask

  task automatic t_stage_copy;
    frame(16'h1234);                       // op 00
    check("R4 code unchanged", {2'b0, code_out}, 16'h0000);
    frame(16'hBFFF);                       // op 10, payload ignored
    check("R6 copy staging", {2'b0, code_out}, 16'h1234);
  endtask

  task automatic t_both;
    frame(16'h6ABC);                       // op 01 payload 2ABC
    check("R5 load both", {2'b0, code_out}, 16'h2ABC);
  endtask

  task automatic t_frame_len;
    cs_n = 1'b0; wait_clk(HALF);
    shift_bits(10, 32'h1FF, 0, 16'd0, 1'b0, 1'b0);
    cs_n = 1'b1; wait_clk(2 * HALF);
    check("R2 short frame dropped", {2'b0, code_out}, 16'h2ABC);
    cs_n = 1'b0; wait_clk(HALF);
    shift_bits(20, 32'hF5111, 0, 16'd0, 1'b0, 1'b0);
    cs_n = 1'b1; wait_clk(2 * HALF);
    check("R2 long frame last 16", {2'b0, code_out}, 16'h1111);
  endtask

  task automatic t_split;
    cs_n = 1'b0; wait_clk(HALF);
    shift_bits(8, 32'h40, 0, 16'd0, 1'b0, 1'b0);
    wait_clk(20);
    shift_bits(8, 32'h0F, 0, 16'd0, 1'b0, 1'b0);
    cs_n = 1'b1; wait_clk(2 * HALF);
    check("R11 split frame", {2'b0, code_out}, 16'h000F);
  endtask

  task automatic t_aux;
    frame(16'hE800);
    check("R7 aux high", {15'd0, aux_out}, 16'd1);
    frame(16'hC000);
    check("R7 nop keeps aux", {15'd0, aux_out}, 16'd1);
    check("R7 nop keeps code", {2'b0, code_out}, 16'h000F);
    frame(16'hE000);
    check("R7 aux low", {15'd0, aux_out}, 16'd0);
  endtask

  task automatic t_sdo_modes;
    frame(16'hC5A5);
    for (int k = 0; k < 16; k++) begin     // clocks and data while deselected
      sdi = 1'b1; sck = 1'b1; wait_clk(HALF);
      sck = 1'b0; wait_clk(HALF);
    end
    check("R3 code unchanged with cs high", {2'b0, code_out}, 16'h000F);
    cs_n = 1'b0; wait_clk(HALF);
    shift_bits(16, 32'hC3C3, 1, 16'hC5A5, 1'b0, 1'b0);  // R3 + R8 rising mode
    cs_n = 1'b1; wait_clk(2 * HALF);
    frame(16'hF000);                       // falling-edge mode
    frame(16'hC5A5);
    cs_n = 1'b0; wait_clk(HALF);
    shift_bits(16, 32'hC3C3, 1, 16'hC5A5, 1'b1, 1'b0);  // R8 falling mode
    cs_n = 1'b1; wait_clk(2 * HALF);
    frame(16'hF800);                       // back to rising-edge mode
  endtask

  task automatic t_sleep;
    frame(16'hE800);                       // aux high, LSB 0
    frame(16'hD000);                       // sleep
    check("R7 shutdown set", {15'd0, shut_out}, 16'd1);
    check("R10 sdo before hold", {15'd0, sdo}, 16'd0);
    cs_n = 1'b0; wait_clk(HALF);
    shift_bits(16, 32'h0155, 2, 16'd0, 1'b0, 1'b0);
    cs_n = 1'b1; wait_clk(2 * HALF);
    check("R10 aux kept", {15'd0, aux_out}, 16'd1);
    check("R4 code unchanged in shutdown", {2'b0, code_out}, 16'h000F);
    frame(16'h8000);
    check("R6 shutdown left", {15'd0, shut_out}, 16'd0);
    check("R6 copy after shutdown", {2'b0, code_out}, 16'h0155);
  endtask

  task automatic t_clear;
    mid_sel = 1'b1; clr_n = 1'b0; wait_clk(6);
    clr_n = 1'b1; wait_clk(6);
    check("R9 clear midscale", {2'b0, code_out}, 16'h2000);
    check("R9 clear aux", {15'd0, aux_out}, 16'd0);
    frame(16'h8000);
    check("R9 staging preset", {2'b0, code_out}, 16'h2000);
    frame(16'h7FFF);
    mid_sel = 1'b0; clr_n = 1'b0; wait_clk(6);
    clr_n = 1'b1; wait_clk(6);
    check("R9 clear zero", {2'b0, code_out}, 16'h0000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; cs_n = 1'b1; sck = 1'b0; sdi = 1'b0; clr_n = 1'b1; mid_sel = 1'b0;
    wait_clk(5);
    rst = 1'b0;
    wait_clk(5);
    t_reset;
    t_stage_copy;
    t_both;
    t_frame_len;
    t_split;
    t_aux;
    t_sdo_modes;
    t_sleep;
    t_clear;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule